// File: doc/BRIEF.md
# Priority-Ordered Peripheral Pin Crossbar

This block places the signals of eight on-chip digital peripherals onto 29 general-purpose pins. The peripherals are ranked. Each enabled peripheral receives, in rank order, the next pins that are still free, so a signal's pin depends on which higher-ranked peripherals are on and which pins software has held back. Pins can be held back in two ways: a per-pin skip mask, or selecting the pin as an analog input. Pins that no peripheral receives remain ordinary port pins and drive the port latch value. Pin index 0 to 7 is port 0, 8 to 15 is port 1, 16 to 23 is port 2, and 24 to 28 is port 3 (bits 0 to 4).

For every pin the block also produces the pad controls. These are the driven value, the driver enable after push-pull or open-drain shaping, and the weak pull-up enable, which can be gated off for all pins by one global control. In the other direction, pad inputs are routed back to the peripheral signal that owns each pin, and to the port read path. The ownership map is held in a register that is recomputed every cycle from the configuration inputs. The data paths through the map are combinational.

Top module: `pin_crossbar`

## Requirements
- R1: Signals are numbered 0..20 in rank order. Enable bit 0 controls signals 0-1, bit 1 controls 2-5, bit 2 controls 6-7, bit 3 controls 8-9, bit 4 controls 10-11, bit 5 controls 12, bit 6 controls 13-18 and bit 7 controls 19-20. The enabled signals, taken in ascending number, occupy the free pins taken in ascending index, one each.
- R2: A pin whose `pin_skip` bit is 1 receives no signal, and allocation continues at the next pin.
- R3: A pin whose `pin_analog` bit is 1 receives no signal. Its `pin_oe`, `pin_out`, `pin_pullup` and `port_rd` bits are all 0.
- R4: When there are more enabled signals than free pins, `overflow` is 1. Each signal that received no pin reads 1 on `sig_in`.
- R5: A digital pin with no owner has `pin_out` equal to its `port_latch` bit, and its output request is 1.
- R6: The output request is the owner's `sig_oe` bit, or 1 for a pin with no owner. With `pin_pushpull`=1, `pin_oe` equals the request. With `pin_pushpull`=0 (open-drain), `pin_oe` is 1 only when the request is 1 and `pin_out` is 0.
- R7: `pin_pullup` is 1 exactly when `pullup_dis` is 0, the pin is digital, and the pin is not actively driving 0.
- R8: A placed signal's `sig_in` equals `pin_in` of its pin. `port_rd` equals `pin_in` on every digital pin.
- R9: The ownership map and `overflow` change only at a rising clock edge, and follow the configuration present before that edge. Reset leaves every pin unowned and `overflow` at 0.
- R10: A peripheral whose enable bit is 0 occupies no pin, and its signals read 1 on `sig_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| periph_en | input | 8 | Peripheral enables, bit 0 is the highest rank |
| pin_skip | input | 29 | Per-pin exclusion from allocation |
| pin_analog | input | 29 | 1 selects analog input for the pin |
| pin_pushpull | input | 29 | 1 push-pull, 0 open-drain |
| pullup_dis | input | 1 | Global weak pull-up disable |
| port_latch | input | 29 | Port output latch values |
| port_rd | output | 29 | Pad value to the port input register |
| sig_out | input | 21 | Peripheral output values |
| sig_oe | input | 21 | Peripheral output requests |
| sig_in | output | 21 | Pad values returned to peripherals |
| pin_in | input | 29 | Pad input values |
| pin_out | output | 29 | Value driven to the pad |
| pin_oe | output | 29 | Pad driver enable |
| pin_pullup | output | 29 | Weak pull-up enable |
| overflow | output | 1 | Not every enabled signal received a pin |

## Verification
Directed patterns cover the following cases:
- All peripherals enabled with no exclusions, which shows the baseline rank-ordered packing.
- Skip gaps at the port start and in mid-range, which show that allocation passes over excluded pins rather than stopping.
- Scattered analog pins, which separate analog exclusion from skip.
- Heavy skipping that makes the free pins run out, which exposes overflow and the idle level on unplaced signals.
- A single low-ranked peripheral, which must start at pin 0.
- All-open-drain runs with the pull-up gate on and off.

Random rounds vary the enables, masks, modes, latch, pad and peripheral data. In each round the outputs are checked twice. The first check comes just after the inputs change and before the clock edge, and it shows that the old map still holds. The second check comes after the edge, and it shows that the new map has taken effect.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

    localparam int NUM_PERIPH = 8;

    typedef enum logic [2:0] {
        PER_UART, PER_SPI, PER_SMB, PER_CMP0,
        PER_CMP1, PER_CLKOUT, PER_PCA, PER_TMR
    } periph_e;

    function automatic int sig_count(int per);
        case (per)
            PER_UART:   return 2;
            PER_SPI:    return 4;
            PER_SMB:    return 2;
            PER_CMP0:   return 2;
            PER_CMP1:   return 2;
            PER_CLKOUT: return 1;
            PER_PCA:    return 6;
            PER_TMR:    return 2;
            default:    return 0;
        endcase
    endfunction

    function automatic int sig_base(int per);
        int acc = 0;
        for (int i = 0; i < per; i++) acc += sig_count(i);
        return acc;
    endfunction

    localparam int NUM_SIG = sig_base(NUM_PERIPH);

    function automatic int periph_of(int sig);
        for (int i = 0; i < NUM_PERIPH; i++)
            if (sig >= sig_base(i) && sig < sig_base(i) + sig_count(i)) return i;
        return 0;
    endfunction

endpackage

// File: rtl/pcx_alloc.sv
module pcx_alloc #(
    parameter int NUM_PINS   = 29,
    parameter int NUM_SIG    = pcx_pkg::NUM_SIG,
    parameter int NUM_PERIPH = pcx_pkg::NUM_PERIPH,
    parameter int PIN_W      = $clog2(NUM_PINS),
    parameter int SIG_W      = $clog2(NUM_SIG)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PERIPH-1:0]            periph_en,
    input  logic [NUM_PINS-1:0]              pin_skip,
    input  logic [NUM_PINS-1:0]              pin_analog,
    output logic [NUM_PINS-1:0]              own_vld,
    output logic [NUM_PINS-1:0][SIG_W-1:0]   own_idx,
    output logic [NUM_SIG-1:0]               sig_vld,
    output logic [NUM_SIG-1:0][PIN_W-1:0]    sig_pin,
    output logic                             ovf
);

    localparam int CNT_W = $clog2(NUM_PINS + NUM_SIG + 1);

    typedef struct packed {
        logic [NUM_PINS-1:0]            own_vld;
        logic [NUM_PINS-1:0][SIG_W-1:0] own_idx;
        logic [NUM_SIG-1:0]             sig_vld;
        logic [NUM_SIG-1:0][PIN_W-1:0]  sig_pin;
        logic                           ovf;
    } map_t;

    map_t map_d, map_q;

    logic [NUM_SIG-1:0]              sig_en;
    logic [NUM_SIG-1:0][CNT_W-1:0]   sig_rank;
    logic [NUM_PINS-1:0]             pin_free;
    logic [NUM_PINS-1:0][CNT_W-1:0]  pin_rank;
    logic [CNT_W-1:0]                total_en;
    logic [CNT_W-1:0]                total_free;

    // each signal inherits the enable of the peripheral it belongs to
    for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig_en
        assign sig_en[s] = periph_en[pcx_pkg::periph_of(s)];
    end

    assign pin_free = ~pin_skip & ~pin_analog;

    // running position of each enabled signal among the enabled ones
    always_comb begin
        logic [CNT_W-1:0] acc;
        acc = '0;
        for (int s = 0; s < NUM_SIG; s++) begin
            sig_rank[s] = acc;
            acc = acc + CNT_W'(sig_en[s]);
        end
        total_en = acc;
    end

    // running position of each free pin among the free ones
    always_comb begin
        logic [CNT_W-1:0] acc;
        acc = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            pin_rank[p] = acc;
            acc = acc + CNT_W'(pin_free[p]);
        end
        total_free = acc;
    end

    // the k-th enabled signal meets the k-th free pin
    always_comb begin
        map_d = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            for (int s = 0; s < NUM_SIG; s++) begin
                if (pin_free[p] && sig_en[s] && pin_rank[p] == sig_rank[s]) begin
                    map_d.own_vld[p] = 1'b1;
                    map_d.own_idx[p] = SIG_W'(s);
                    map_d.sig_vld[s] = 1'b1;
                    map_d.sig_pin[s] = PIN_W'(p);
                end
            end
        end
        map_d.ovf = total_en > total_free;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) map_q <= '0;
        else        map_q <= map_d;
    end

    assign own_vld = map_q.own_vld;
    assign own_idx = map_q.own_idx;
    assign sig_vld = map_q.sig_vld;
    assign sig_pin = map_q.sig_pin;
    assign ovf     = map_q.ovf;

    // R4: under overflow no pin that was free is left without an owner
    a_r4_overflow_fills: assert property (@(posedge clk) disable iff (!rst_n)
        map_q.ovf |-> &(map_q.own_vld | ~$past(pin_free)));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
        // R2 / R3: an owned pin was free under the configuration before the edge
        a_r2_owner_on_free_pin: assert property (@(posedge clk) disable iff (!rst_n)
            map_q.own_vld[p] |-> $past(pin_free[p]));
    end

    for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig_chk
        // R1: the pin-side and signal-side views of the map agree
        a_r1_map_consistent: assert property (@(posedge clk) disable iff (!rst_n)
            map_q.sig_vld[s] |-> (map_q.own_vld[map_q.sig_pin[s]] &&
                                  map_q.own_idx[map_q.sig_pin[s]] == SIG_W'(s)));
        // R10: a signal of a disabled peripheral never holds a pin
        a_r10_disabled_unplaced: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(sig_en[s]) |-> !map_q.sig_vld[s]);
    end

endmodule

// File: rtl/pcx_pin_drive.sv
module pcx_pin_drive #(
    parameter int NUM_SIG = pcx_pkg::NUM_SIG,
    parameter int SIG_W   = $clog2(NUM_SIG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               analog,
    input  logic               pushpull,
    input  logic               pullup_dis,
    input  logic               own_vld,
    input  logic [SIG_W-1:0]   own_idx,
    input  logic [NUM_SIG-1:0] sig_out,
    input  logic [NUM_SIG-1:0] sig_oe,
    input  logic               latch,
    input  logic               pad_in,
    output logic               drv_val,
    output logic               drv_oe,
    output logic               pull_en,
    output logic               rd_val
);

    logic src_val, src_req;

    always_comb begin
        if (own_vld && int'(own_idx) < NUM_SIG) begin
            src_val = sig_out[own_idx];
            src_req = sig_oe[own_idx];
        end else begin
            src_val = latch;
            src_req = 1'b1;
        end
    end

    always_comb begin
        if (analog) begin
            drv_val = 1'b0;
            drv_oe  = 1'b0;
            pull_en = 1'b0;
            rd_val  = 1'b0;
        end else begin
            drv_val = src_val;
            drv_oe  = pushpull ? src_req : (src_req & ~src_val);
            pull_en = ~pullup_dis & ~(drv_oe & ~src_val);
            rd_val  = pad_in;
        end
    end

    // R6: an open-drain driver is only ever on while pulling low
    a_r6_open_drain_low_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!pushpull && drv_oe) |-> !drv_val);

    // R3: an analog pin is neither driven nor pulled
    a_r3_analog_silent: assert property (@(posedge clk) disable iff (!rst_n)
        analog |-> (!drv_oe && !pull_en));

endmodule

// File: rtl/pcx_sig_return.sv
module pcx_sig_return #(
    parameter int NUM_PINS = 29,
    parameter int PIN_W    = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                placed,
    input  logic [PIN_W-1:0]    pin_idx,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic                sig_in
);

    always_comb begin
        if (placed && int'(pin_idx) < NUM_PINS) sig_in = pad_in[pin_idx];
        else                                   sig_in = 1'b1;
    end

    // R4 / R10: a signal without a pin sees the idle level
    a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !placed |-> sig_in);

endmodule

// File: rtl/pin_crossbar.sv
module pin_crossbar #(
    parameter int NUM_PINS = 29
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [pcx_pkg::NUM_PERIPH-1:0]    periph_en,
    input  logic [NUM_PINS-1:0]               pin_skip,
    input  logic [NUM_PINS-1:0]               pin_analog,
    input  logic [NUM_PINS-1:0]               pin_pushpull,
    input  logic                              pullup_dis,
    input  logic [NUM_PINS-1:0]               port_latch,
    output logic [NUM_PINS-1:0]               port_rd,
    input  logic [pcx_pkg::NUM_SIG-1:0]       sig_out,
    input  logic [pcx_pkg::NUM_SIG-1:0]       sig_oe,
    output logic [pcx_pkg::NUM_SIG-1:0]       sig_in,
    input  logic [NUM_PINS-1:0]               pin_in,
    output logic [NUM_PINS-1:0]               pin_out,
    output logic [NUM_PINS-1:0]               pin_oe,
    output logic [NUM_PINS-1:0]               pin_pullup,
    output logic                              overflow
);

    localparam int NUM_SIG = pcx_pkg::NUM_SIG;
    localparam int PIN_W   = $clog2(NUM_PINS);
    localparam int SIG_W   = $clog2(NUM_SIG);

    logic [NUM_PINS-1:0]            own_vld;
    logic [NUM_PINS-1:0][SIG_W-1:0] own_idx;
    logic [NUM_SIG-1:0]             sig_vld;
    logic [NUM_SIG-1:0][PIN_W-1:0]  sig_pin;

    pcx_alloc #(
        .NUM_PINS   (NUM_PINS),
        .NUM_SIG    (NUM_SIG),
        .NUM_PERIPH (pcx_pkg::NUM_PERIPH),
        .PIN_W      (PIN_W),
        .SIG_W      (SIG_W)
    ) u_alloc (
        .clk        (clk),
        .rst_n      (rst_n),
        .periph_en  (periph_en),
        .pin_skip   (pin_skip),
        .pin_analog (pin_analog),
        .own_vld    (own_vld),
        .own_idx    (own_idx),
        .sig_vld    (sig_vld),
        .sig_pin    (sig_pin),
        .ovf        (overflow)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pcx_pin_drive #(
            .NUM_SIG (NUM_SIG),
            .SIG_W   (SIG_W)
        ) u_drive (
            .clk        (clk),
            .rst_n      (rst_n),
            .analog     (pin_analog[p]),
            .pushpull   (pin_pushpull[p]),
            .pullup_dis (pullup_dis),
            .own_vld    (own_vld[p]),
            .own_idx    (own_idx[p]),
            .sig_out    (sig_out),
            .sig_oe     (sig_oe),
            .latch      (port_latch[p]),
            .pad_in     (pin_in[p]),
            .drv_val    (pin_out[p]),
            .drv_oe     (pin_oe[p]),
            .pull_en    (pin_pullup[p]),
            .rd_val     (port_rd[p])
        );

        // R7: the weak pull-up never fights an active low drive
        a_r7_pullup_not_fighting: assert property (@(posedge clk) disable iff (!rst_n)
            pin_pullup[p] |-> !(pin_oe[p] && !pin_out[p]));
    end

    for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig
        pcx_sig_return #(
            .NUM_PINS (NUM_PINS),
            .PIN_W    (PIN_W)
        ) u_ret (
            .clk     (clk),
            .rst_n   (rst_n),
            .placed  (sig_vld[s]),
            .pin_idx (sig_pin[s]),
            .pad_in  (pin_in),
            .sig_in  (sig_in[s])
        );
    end

endmodule

// File: tb/pin_crossbar_test.sv
module pin_crossbar_test;

    localparam int NP = 29;
    localparam int NS = 21;
    localparam int NPER = 8;
    localparam int CNT [NPER] = '{2, 4, 2, 2, 2, 1, 6, 2};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NPER-1:0] periph_en = '0;
    logic [NP-1:0] pin_skip = '0, pin_analog = '0, pin_pushpull = '0;
    logic pullup_dis = 1'b0;
    logic [NP-1:0] port_latch = '0, pin_in = '0;
    logic [NS-1:0] sig_out = '0, sig_oe = '0;
    logic [NP-1:0] port_rd, pin_out, pin_oe, pin_pullup;
    logic [NS-1:0] sig_in;
    logic overflow;

    always #4 clk = ~clk;

    pin_crossbar uut (
        .clk(clk), .rst_n(rst_n), .periph_en(periph_en),
        .pin_skip(pin_skip), .pin_analog(pin_analog), .pin_pushpull(pin_pushpull),
        .pullup_dis(pullup_dis), .port_latch(port_latch), .port_rd(port_rd),
        .sig_out(sig_out), .sig_oe(sig_oe), .sig_in(sig_in), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pullup(pin_pullup),
        .overflow(overflow)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // model of the registered ownership map
    int  m_owner [NP];
    int  m_pin [NS];
    bit  m_ovf;

    task automatic model_clear();
        for (int p = 0; p < NP; p++) m_owner[p] = -1;
        for (int s = 0; s < NS; s++) m_pin[s] = -1;
        m_ovf = 0;
    endtask

    // sequential walk: peripherals by rank, each signal on the next free pin
    task automatic model_build();
        int ptr = 0;
        int sig = 0;
        model_clear();
        for (int per = 0; per < NPER; per++) begin
            for (int k = 0; k < CNT[per]; k++) begin
                if (periph_en[per]) begin
                    while (ptr < NP && (pin_skip[ptr] || pin_analog[ptr])) ptr++;
                    if (ptr < NP) begin
                        m_owner[ptr] = sig;
                        m_pin[sig] = ptr;
                        ptr++;
                    end else m_ovf = 1;
                end
                sig++;
            end
        end
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string phase);
        logic [NP-1:0] e_out, e_oe, e_pu, e_rd;
        logic [NS-1:0] e_sin;
        for (int p = 0; p < NP; p++) begin
            logic v, r;
            if (m_owner[p] >= 0) begin
                v = sig_out[m_owner[p]];
                r = sig_oe[m_owner[p]];
            end else begin
                v = port_latch[p];
                r = 1'b1;
            end
            if (pin_analog[p]) begin
                e_out[p] = 0; e_oe[p] = 0; e_pu[p] = 0; e_rd[p] = 0;
            end else begin
                e_out[p] = v;
                e_oe[p]  = pin_pushpull[p] ? r : (r && !v);
                e_pu[p]  = !pullup_dis && !(e_oe[p] && !v);
                e_rd[p]  = pin_in[p];
            end
        end
        for (int s = 0; s < NS; s++)
            e_sin[s] = (m_pin[s] >= 0) ? pin_in[m_pin[s]] : 1'b1;
        chk({phase, " R1 R5 pin_out"}, 32'(pin_out), 32'(e_out));
        chk({phase, " R6 pin_oe"}, 32'(pin_oe), 32'(e_oe));
        chk({phase, " R7 pin_pullup"}, 32'(pin_pullup), 32'(e_pu));
        chk({phase, " R3 R8 port_rd"}, 32'(port_rd), 32'(e_rd));
        chk({phase, " R4 R8 R10 sig_in"}, 32'(sig_in), 32'(e_sin));
        chk({phase, " R4 overflow"}, 32'(overflow), 32'(m_ovf));
    endtask

    task automatic rand_data();
        port_latch = NP'($urandom);
        pin_in     = NP'($urandom);
        sig_out    = NS'($urandom);
        sig_oe     = NS'($urandom);
    endtask

    // new configuration at a falling edge: old map first (R9), then the new one
    task automatic apply(string phase, logic [NPER-1:0] en, logic [NP-1:0] sk,
                         logic [NP-1:0] an, logic [NP-1:0] pp, logic pud);
        @(negedge clk);
        periph_en = en; pin_skip = sk; pin_analog = an;
        pin_pushpull = pp; pullup_dis = pud;
        rand_data();
        #1;
        check_all({phase, " R9 before edge"});
        @(posedge clk);
        #2;
        model_build();
        check_all({phase, " after edge"});
        rand_data();
        #1;
        check_all({phase, " data only"});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        repeat (3) @(posedge clk);
        #2;
        // R9: reset state, nothing owned, no overflow
        check_all("reset R9");
        @(negedge clk);
        rst_n = 1'b1;

        // R1: everything enabled, no exclusions, signals fill pins 0..20
        apply("all on R1", 8'hFF, '0, '0, '1, 1'b0);
        chk("R1 last timer signal on pin 20", 32'(m_pin[20]), 32'd20);
        // R2: skip gaps at the start and mid-range
        apply("skip R2", 8'hFF, 29'h0000_040F, '0, '1, 1'b0);
        chk("R2 first signal lands on pin 4", 32'(m_pin[0]), 32'd4);
        // R3: analog pins are passed over and silent
        apply("analog R3", 8'hFF, '0, 29'h0000_0022, 29'h0F0F_0F0F, 1'b0);
        // R4: few free pins, overflow with idle-high leftovers
        apply("overflow R4", 8'hFF, 29'h0FFF_F000, 29'h0000_0003, '1, 1'b0);
        chk("R4 overflow flagged", 32'(overflow), 32'd1);
        // R10: only the PCA group, it must start at pin 0
        apply("single R10", 8'h40, '0, '0, '1, 1'b0);
        chk("R10 first PCA signal on pin 0", 32'(m_pin[13]), 32'd0);
        // R6 / R7: all open-drain, pull-ups gated on then off
        apply("open drain R6", 8'h0F, 29'h0000_0100, '0, '0, 1'b0);
        apply("pullups off R7", 8'h0F, 29'h0000_0100, '0, '0, 1'b1);
        // R5: nothing enabled, every digital pin is a port pin
        apply("gpio R5", 8'h00, '0, 29'h1000_0001, 29'h1555_5555, 1'b0);

        for (int i = 0; i < 300; i++) begin
            logic [NP-1:0] sk, an;
            sk = NP'($urandom & $urandom);
            if (i % 7 == 0) sk = NP'($urandom | $urandom);
            an = NP'($urandom & $urandom & $urandom);
            apply("random", NPER'($urandom), sk, an, NP'($urandom), 1'($urandom));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule